// File: doc/BRIEF.md
# Operand Effective-Address Sequencer

This block sits behind an instruction decoder and turns the operand bytes that follow an opcode into a 16-bit effective address. A one-cycle `start` pulse latches a mode tag and a snapshot of the four address registers (two index registers, the stack pointer and the program counter). The operand bytes then arrive one per accepted cycle on a valid-qualified byte lane. The block accepts every byte that arrives while it is collecting. Idle cycles between bytes are allowed.

Once it has the last byte the mode needs, the block pulses `done` for one cycle. At the same time it presents the address and the number of operand bytes it consumed. Address arithmetic wraps at 16 bits. The supported forms are: page-zero (one low byte), absolute (two bytes), short and long PC-relative, and three indexed forms selected by a postbyte. The indexed forms carry a 5-bit offset inside the postbyte, a 9-bit offset spread over the postbyte and one extra byte, or a 16-bit offset in two extra bytes. Postbyte patterns outside these three forms raise `fault` and produce no address. Undefined mode tags also raise `fault`.

Top module: `eff_addr_unit`

## Requirements
- R1: After reset `done` and `fault` are low and `ea` and `nbytes` are zero.
- R2: Mode code 0 (page-zero) consumes one byte B and gives `ea` = {0x00, B} with `nbytes` = 1. `done` is high for exactly the cycle after the edge that accepts the last operand byte.
- R3: Mode code 1 (absolute) consumes two bytes, the high byte first, and gives that 16-bit value with `nbytes` = 2. Cycles with `ob_valid` low between the bytes do not change the result.
- R4: Mode code 2 (short relative) consumes one byte and gives `ea` = P + 1 + sign-extended byte. P is `pc_val` at start and is the address of the first operand byte.
- R5: Mode code 3 (long relative) consumes two bytes (a signed 16-bit offset, high byte first) and gives `ea` = P + 2 + offset.
- R6: Mode code 4 (indexed) with postbyte bit 5 = 0 is a one-byte form. Bits 7:6 select the base register: 00 = X, 01 = Y, 10 = SP, 11 = PC. Bits 4:0 are a signed offset. `nbytes` = 1.
- R7: Indexed postbyte 111rr00n (bits 4:3 = base register) is followed by one byte. Bit 0 of the postbyte is the sign bit above that byte, giving a 9-bit signed offset. `nbytes` = 2.
- R8: Indexed postbyte 111rr010 is followed by two bytes forming a 16-bit offset, high byte first. `nbytes` = 3.
- R9: In indexed forms the PC base is P + `nbytes`. Any other postbyte raises `fault` for one cycle after the edge that accepts the postbyte. In that case `done` stays low, `ea` and `nbytes` keep their previous values, and no further byte is taken.
- R10: A start with mode code 5, 6 or 7 raises `fault` in the cycle after the start edge. No byte is then consumed.
- R11: `start` is ignored while bytes are being collected. `ob_valid` is ignored while the block is idle.
- R12: The register values sampled at start are used. Later changes on `x_val`, `y_val`, `sp_val` and `pc_val` have no effect on the address being built.
- R13: All address sums wrap modulo 2^16. `done` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a decode (taken only when idle) |
| mode | input | 3 | Mode code 0..4, others undefined |
| x_val | input | 16 | Index register X |
| y_val | input | 16 | Index register Y |
| sp_val | input | 16 | Stack pointer |
| pc_val | input | 16 | Address of the first operand byte |
| ob_valid | input | 1 | Operand byte lane valid |
| ob_data | input | 8 | Operand byte |
| ea | output | 16 | Effective address, updated with `done` |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle unsupported-form pulse |
| nbytes | output | 2 | Operand bytes consumed by last completed decode |

## Verification
Two events can meet in one cycle: the final operand byte of one decode, and a new start request. The bench raises `start` with a different mode in exactly the cycle that carries the last byte. It then requires the completed address and byte count to be those of the original mode. It also requires that the bytes offered right afterwards, while the block is idle, produce no second `done`. A second collision is also provoked: a byte offered in the same cycle as an undefined-mode start. That byte must be dropped, and the next legal decode must return its own value.

// File: rtl/eau_pkg.sv
package eau_pkg;
  localparam int EA_W   = 16;
  localparam int OB_W   = 8;
  localparam int MAX_OB = 3;
  localparam int CNT_W  = $clog2(MAX_OB + 1);

  typedef logic [EA_W-1:0] addr_t;
  typedef logic [OB_W-1:0] obyte_t;
  typedef logic [CNT_W-1:0] cnt_t;

  localparam logic [2:0] MD_DIR   = 3'd0;
  localparam logic [2:0] MD_EXT   = 3'd1;
  localparam logic [2:0] MD_REL8  = 3'd2;
  localparam logic [2:0] MD_REL16 = 3'd3;
  localparam logic [2:0] MD_IDX   = 3'd4;

  typedef enum logic [1:0] {PB_OFF5, PB_OFF9, PB_OFF16, PB_BAD} pb_kind_e;

  function automatic pb_kind_e pb_classify(obyte_t pb);
    if (!pb[5])                                   return PB_OFF5;
    else if (pb[7:5] == 3'b111 && pb[2:1] == 2'b00) return PB_OFF9;
    else if (pb[7:5] == 3'b111 && pb[2:0] == 3'b010) return PB_OFF16;
    else                                          return PB_BAD;
  endfunction

  function automatic logic [1:0] pb_base_sel(obyte_t pb);
    return pb[5] ? pb[4:3] : pb[7:6];
  endfunction

  function automatic cnt_t pb_len(pb_kind_e k);
    case (k)
      PB_OFF9:  return cnt_t'(2);
      PB_OFF16: return cnt_t'(3);
      default:  return cnt_t'(1);
    endcase
  endfunction

  function automatic addr_t sext8(obyte_t b);
    return {{(EA_W-OB_W){b[OB_W-1]}}, b};
  endfunction

  function automatic addr_t idx_offset(pb_kind_e k, obyte_t b0, obyte_t b1, obyte_t b2);
    case (k)
      PB_OFF5:  return {{(EA_W-5){b0[4]}}, b0[4:0]};
      PB_OFF9:  return {{(EA_W-OB_W){b0[0]}}, b1};
      PB_OFF16: return {b1, b2};
      default:  return '0;
    endcase
  endfunction

  function automatic addr_t pick_base(logic [1:0] rr, addr_t x, addr_t y, addr_t sp, addr_t pcb);
    case (rr)
      2'b00:   return x;
      2'b01:   return y;
      2'b10:   return sp;
      default: return pcb;
    endcase
  endfunction
endpackage

// File: rtl/eau_pb_decode.sv
module eau_pb_decode
  import eau_pkg::*;
(
  input  obyte_t     pb,
  output pb_kind_e   kind,
  output logic [1:0] rr,
  output cnt_t       len
);
  always_comb begin
    kind = pb_classify(pb);
    rr   = pb_base_sel(pb);
    len  = pb_len(kind);
  end
endmodule

// File: rtl/eau_ea_calc.sv
module eau_ea_calc
  import eau_pkg::*;
(
  input  logic [2:0]                   mode_q,
  input  logic [MAX_OB-1:0][OB_W-1:0]  nbuf,
  input  addr_t                        x_q,
  input  addr_t                        y_q,
  input  addr_t                        sp_q,
  input  addr_t                        pc_q,
  output addr_t                        ea_calc,
  output cnt_t                         len_calc,
  output logic                         pb_bad
);
  obyte_t     b0, b1, b2;
  pb_kind_e   kind;
  logic [1:0] rr;
  cnt_t       ilen;
  addr_t      pc_after;

  assign b0 = nbuf[0];
  assign b1 = nbuf[1];
  assign b2 = nbuf[2];

  eau_pb_decode u_dec (.pb(b0), .kind(kind), .rr(rr), .len(ilen));

  assign pb_bad   = (kind == PB_BAD);
  assign pc_after = pc_q + addr_t'(ilen);

  always_comb begin
    ea_calc  = '0;
    len_calc = cnt_t'(1);
    case (mode_q)
      MD_DIR:   ea_calc = {{(EA_W-OB_W){1'b0}}, b0};
      MD_EXT: begin
        ea_calc  = {b0, b1};
        len_calc = cnt_t'(2);
      end
      MD_REL8:  ea_calc = pc_q + addr_t'(1) + sext8(b0);
      MD_REL16: begin
        ea_calc  = pc_q + addr_t'(2) + {b0, b1};
        len_calc = cnt_t'(2);
      end
      MD_IDX: begin
        len_calc = ilen;
        ea_calc  = pick_base(rr, x_q, y_q, sp_q, pc_after) + idx_offset(kind, b0, b1, b2);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/eau_seq.sv
module eau_seq
  import eau_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [2:0]                   mode_in,
  input  addr_t                        x_in,
  input  addr_t                        y_in,
  input  addr_t                        sp_in,
  input  addr_t                        pc_in,
  input  logic                         ob_valid,
  input  obyte_t                       ob_data,
  input  cnt_t                         need_len,
  input  logic                         pb_bad,
  output logic                         busy,
  output logic                         accept,
  output logic                         finish,
  output logic                         fault_ev,
  output logic [2:0]                   mode_q,
  output logic [MAX_OB-1:0][OB_W-1:0]  nbuf,
  output addr_t                        x_q,
  output addr_t                        y_q,
  output addr_t                        sp_q,
  output addr_t                        pc_q
);
  logic                        busy_q;
  cnt_t                        cnt_q;
  logic [MAX_OB-1:0][OB_W-1:0] buf_q;
  logic                        bad_pb_ev, bad_mode_ev;

  assign busy   = busy_q;
  assign accept = busy_q && ob_valid;

  always_comb begin
    nbuf = buf_q;
    for (int i = 0; i < MAX_OB; i++)
      if (accept && cnt_q == cnt_t'(i)) nbuf[i] = ob_data;
  end

  assign bad_pb_ev   = accept && (cnt_q == '0) && (mode_q == MD_IDX) && pb_bad;
  assign bad_mode_ev = !busy_q && start && (mode_in > MD_IDX);
  assign finish      = accept && !bad_pb_ev && (cnt_t'(cnt_q + cnt_t'(1)) == need_len);
  assign fault_ev    = bad_pb_ev || bad_mode_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      buf_q  <= '0;
      mode_q <= MD_DIR;
      x_q    <= '0;
      y_q    <= '0;
      sp_q   <= '0;
      pc_q   <= '0;
    end else if (!busy_q) begin
      if (start && mode_in <= MD_IDX) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        mode_q <= mode_in;
        x_q    <= x_in;
        y_q    <= y_in;
        sp_q   <= sp_in;
        pc_q   <= pc_in;
      end
    end else if (accept) begin
      for (int i = 0; i < MAX_OB; i++)
        if (cnt_q == cnt_t'(i)) buf_q[i] <= ob_data;
      if (finish || bad_pb_ev) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + cnt_t'(1);
      end
    end
  end
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
  import eau_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  mode,
  input  logic [15:0] x_val,
  input  logic [15:0] y_val,
  input  logic [15:0] sp_val,
  input  logic [15:0] pc_val,
  input  logic        ob_valid,
  input  logic [7:0]  ob_data,
  output logic [15:0] ea,
  output logic        done,
  output logic        fault,
  output logic [1:0]  nbytes
);
  logic                        seq_busy, seq_accept, seq_finish, seq_fault;
  logic [2:0]                  seq_mode;
  logic [MAX_OB-1:0][OB_W-1:0] seq_nbuf;
  addr_t                       x_q, y_q, sp_q, pc_q;
  addr_t                       calc_ea;
  cnt_t                        calc_len;
  logic                        calc_pb_bad;

  eau_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode),
    .x_in(x_val), .y_in(y_val), .sp_in(sp_val), .pc_in(pc_val),
    .ob_valid(ob_valid), .ob_data(ob_data),
    .need_len(calc_len), .pb_bad(calc_pb_bad),
    .busy(seq_busy), .accept(seq_accept), .finish(seq_finish), .fault_ev(seq_fault),
    .mode_q(seq_mode), .nbuf(seq_nbuf),
    .x_q(x_q), .y_q(y_q), .sp_q(sp_q), .pc_q(pc_q)
  );

  eau_ea_calc u_calc (
    .mode_q(seq_mode), .nbuf(seq_nbuf),
    .x_q(x_q), .y_q(y_q), .sp_q(sp_q), .pc_q(pc_q),
    .ea_calc(calc_ea), .len_calc(calc_len), .pb_bad(calc_pb_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea     <= '0;
      nbytes <= '0;
      done   <= 1'b0;
      fault  <= 1'b0;
    end else begin
      done  <= seq_finish;
      fault <= seq_fault;
      if (seq_finish) begin
        ea     <= calc_ea;
        nbytes <= calc_len;
      end
    end
  end
endmodule

// File: rtl/eau_chk.sv
module eau_chk
  import eau_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        done,
  input logic        fault,
  input logic [15:0] ea,
  input logic [1:0]  nbytes,
  input logic        busy,
  input logic        accept,
  input logic [2:0]  mode_q
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R13
  AST_DONE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(accept)); // R2
  AST_PAGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == MD_DIR) |-> (ea[15:8] == 8'h00 && nbytes == 2'd1)); // R2
  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) done |-> nbytes != 2'd0); // R8
  AST_NO_DONE_WITH_FAULT: assert property (@(posedge clk) disable iff (!rst_n) !(done && fault)); // R9
  AST_FAULT_HOLDS_EA: assert property (@(posedge clk) disable iff (!rst_n) fault |-> $stable(ea)); // R9
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mode_q)); // R11
endmodule

bind eff_addr_unit eau_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .fault(fault),
  .ea(ea), .nbytes(nbytes), .busy(seq_busy), .accept(seq_accept), .mode_q(seq_mode)
);

// File: tb/eff_addr_unit_tb.sv
`timescale 1ns/1ps
module eff_addr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [15:0] x_val = 16'h0, y_val = 16'h0, sp_val = 16'h0, pc_val = 16'h0;
  logic        ob_valid = 1'b0;
  logic [7:0]  ob_data = 8'h0;
  logic [15:0] ea;
  logic        done, fault;
  logic [1:0]  nbytes;

  int nvec = 0, nbad = 0;
  logic        s_done, s_fault;
  logic [15:0] s_ea;
  logic [1:0]  s_nb;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  eff_addr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .x_val(x_val), .y_val(y_val), .sp_val(sp_val), .pc_val(pc_val),
    .ob_valid(ob_valid), .ob_data(ob_data),
    .ea(ea), .done(done), .fault(fault), .nbytes(nbytes)
  );

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Independent reference: integer arithmetic, postbyte matched by masks.
  function automatic int model(input int md, input int b0, input int b1, input int b2, output int len);
    int off, r, base;
    len = 0; off = 0; r = 0;
    case (md)
      0: begin len = 1; return b0; end
      1: begin len = 2; return (b0 << 8) | b1; end
      2: begin len = 1; off = (b0 >= 128) ? b0 - 256 : b0; return (pc_val + 1 + off) & 'hFFFF; end
      3: begin len = 2; off = (b0 << 8) | b1; if (off >= 32768) off -= 65536;
               return (pc_val + 2 + off) & 'hFFFF; end
      default: begin
        if ((b0 & 'h20) == 0) begin
          len = 1; r = b0 >> 6; off = b0 & 31; if (off >= 16) off -= 32;
        end else if ((b0 & 'hE6) == 'hE0) begin
          len = 2; r = (b0 >> 3) & 3; off = ((b0 & 1) << 8) | b1; if (off >= 256) off -= 512;
        end else if ((b0 & 'hE7) == 'hE2) begin
          len = 3; r = (b0 >> 3) & 3; off = (b1 << 8) | b2; if (off >= 32768) off -= 65536;
        end else return -1;
        base = (r == 0) ? x_val : (r == 1) ? y_val : (r == 2) ? sp_val : pc_val + len;
        return (base + off) & 'hFFFF;
      end
    endcase
  endfunction

  task automatic op(input logic [2:0] md, input int n, input logic [7:0] p0, p1, p2, input int gap);
    @(negedge clk); start = 1'b1; mode = md;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i > 0 && gap > 0) begin ob_valid = 1'b0; repeat (gap) @(negedge clk); end
      ob_valid = 1'b1;
      ob_data  = (i == 0) ? p0 : (i == 1) ? p1 : p2;
      @(negedge clk);
    end
    ob_valid = 1'b0;
    s_done = done; s_fault = fault; s_ea = ea; s_nb = nbytes;
  endtask

  task automatic good(input string req, input logic [2:0] md, input logic [7:0] p0, p1, p2, input int gap);
    int len, e;
    e = model(md, p0, p1, p2, len);
    op(md, len, p0, p1, p2, gap);
    chk({req, " done"}, s_done, 1);
    chk({req, " ea"}, s_ea, e);
    chk({req, " nbytes"}, s_nb, len);
    @(negedge clk);
    chk({req, " done drops"}, done, 0);
  endtask

  task automatic t_reset();
    chk("R1 done", done, 0);
    chk("R1 fault", fault, 0);
    chk("R1 ea", ea, 0);
    chk("R1 nbytes", nbytes, 0);
  endtask

  task automatic t_direct_abs();
    good("R2 page0", 3'd0, 8'h80, 8'h00, 8'h00, 0);
    good("R2 page0 ff", 3'd0, 8'hFF, 8'h00, 8'h00, 0);
    good("R3 absolute", 3'd1, 8'h30, 8'h00, 8'h00, 0);
    good("R3 absolute gap", 3'd1, 8'hA1, 8'h29, 8'h00, 3);
  endtask

  task automatic t_relative();
    pc_val = 16'h2001;
    good("R4 short fwd", 3'd2, 8'h5E, 8'h00, 8'h00, 0);
    chk("R4 fwd value", s_ea, 16'h2060);
    good("R4 short back", 3'd2, 8'hEE, 8'h00, 8'h00, 0);
    chk("R4 back value", s_ea, 16'h1FF0);
    pc_val = 16'hFFFE;
    good("R13 wrap short", 3'd2, 8'h10, 8'h00, 8'h00, 0);
    chk("R13 wrap value", s_ea, 16'h000F);
    pc_val = 16'h4000;
    good("R5 long back", 3'd3, 8'hFF, 8'h00, 8'h00, 0);
    chk("R5 long value", s_ea, 16'h3F02);
    good("R5 long fwd", 3'd3, 8'h12, 8'h34, 8'h00, 1);
  endtask

  task automatic t_indexed();
    x_val = 16'h1000; y_val = 16'h1000; sp_val = 16'h0800; pc_val = 16'h6000;
    good("R6 y+4", 3'd4, 8'h44, 8'h00, 8'h00, 0);
    chk("R6 y+4 value", s_ea, 16'h1004);
    good("R6 x-1", 3'd4, 8'h1F, 8'h00, 8'h00, 0);
    good("R6 sp-16", 3'd4, 8'h90, 8'h00, 8'h00, 0);
    good("R6 pc-1", 3'd4, 8'hDF, 8'h00, 8'h00, 0);
    chk("R9 pc base 5bit", s_ea, 16'h6000);
    good("R7 x-100", 3'd4, 8'hE1, 8'h9C, 8'h00, 0);
    chk("R7 x-100 value", s_ea, 16'h0F9C);
    good("R7 pc+16", 3'd4, 8'hF8, 8'h10, 8'h00, 0);
    chk("R9 pc base 9bit", s_ea, 16'h6012);
    good("R8 y-1000", 3'd4, 8'hEA, 8'hFC, 8'h18, 0);
    chk("R8 y-1000 value", s_ea, 16'h0C18);
    good("R8 sp+1234", 3'd4, 8'hF2, 8'h12, 8'h34, 2);
    good("R8 pc+5", 3'd4, 8'hFA, 8'h00, 8'h05, 0);
    chk("R9 pc base 16bit", s_ea, 16'h6008);
  endtask

  task automatic t_bad_postbyte(input logic [7:0] pb);
    logic [15:0] old_ea;
    logic [1:0]  old_nb;
    old_ea = ea; old_nb = nbytes;
    op(3'd4, 1, pb, 8'h00, 8'h00, 0);
    chk("R9 fault", s_fault, 1);
    chk("R9 no done", s_done, 0);
    chk("R9 ea kept", s_ea, old_ea);
    chk("R9 nbytes kept", s_nb, old_nb);
    // Unit must be idle again: a byte now is dropped, then a fresh decode works.
    ob_valid = 1'b1; ob_data = 8'h77;
    @(negedge clk); ob_valid = 1'b0;
    chk("R9 no extra done", done, 0);
    good("R9 recover", 3'd0, 8'h42, 8'h00, 8'h00, 0);
  endtask

  task automatic t_bad_mode();
    @(negedge clk); start = 1'b1; mode = 3'd6; ob_valid = 1'b1; ob_data = 8'h55;
    @(negedge clk); start = 1'b0;
    chk("R10 fault", fault, 1);
    chk("R10 no done", done, 0);
    @(negedge clk); ob_valid = 1'b0;
    chk("R11 idle byte ignored", done, 0);
    good("R10 after", 3'd0, 8'h21, 8'h00, 8'h00, 0);
    chk("R11 value after idle bytes", s_ea, 16'h0021);
  endtask

  task automatic t_start_collision();
    @(negedge clk); start = 1'b1; mode = 3'd1;
    @(negedge clk); start = 1'b0; ob_valid = 1'b1; ob_data = 8'h12;
    @(negedge clk); ob_data = 8'h34; start = 1'b1; mode = 3'd0;
    @(negedge clk); start = 1'b0; ob_data = 8'h99;
    chk("R11 done", done, 1);
    chk("R11 ea kept mode", ea, 16'h1234);
    chk("R11 nbytes", nbytes, 2);
    @(negedge clk); ob_valid = 1'b0;
    chk("R11 ignored start", done, 0);
    @(negedge clk);
    chk("R11 still idle", done, 0);
  endtask

  task automatic t_snapshot();
    pc_val = 16'h3000;
    @(negedge clk); start = 1'b1; mode = 3'd2;
    @(negedge clk); start = 1'b0; pc_val = 16'h5000; x_val = 16'hDEAD;
    ob_valid = 1'b1; ob_data = 8'h04;
    @(negedge clk); ob_valid = 1'b0;
    chk("R12 pc snapshot", ea, 16'h3005);
    x_val = 16'h0200;
    @(negedge clk); start = 1'b1; mode = 3'd4;
    @(negedge clk); start = 1'b0; x_val = 16'h9999; ob_valid = 1'b1; ob_data = 8'h02;
    @(negedge clk); ob_valid = 1'b0;
    chk("R12 x snapshot", ea, 16'h0202);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct_abs();
    t_relative();
    t_indexed();
    t_bad_postbyte(8'h23);
    t_bad_postbyte(8'hE3);
    t_bad_postbyte(8'hE4);
    t_bad_mode();
    t_start_collision();
    t_snapshot();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      nvec++; nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule